// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block drives the four enables that bring a flat panel up and down in a safe order: the panel logic supply, the video interface signals, the backlight low-voltage supply and the backlight on/off control. A level request asks for the panel to be on or off. A one-cycle pulse once per millisecond sets the time base for every delay. The block holds the interface signals low unless the logic supply is up. It keeps the backlight dark until video has been valid for a long settling time. After every shutdown it keeps the logic supply off for a minimum time before it will restart.

Power-up runs in this order: supply, then signals, then backlight supply, then backlight on. Power-down runs in the reverse order. If the request drops partway through power-up, the block turns off whatever is already on, in power-down order. A busy flag covers every transition and the restart lockout. A ready flag marks the fully-on state. Each delay is a parameter in milliseconds. A delay of `d` waits for `d+1` tick pulses, so that at least `d` full milliseconds pass whatever the tick phase. A delay of 0 waits for no tick, and the next step follows one clock later.

Top module: `panel_pwr_seq`

## Requirements
- R1: During reset and after it, all four enables are 0, busy is 1 and ready is 0. The block enters the restart lockout, and busy drops once the lockout delay has elapsed (150 ms by default, so 151 tick pulses).
- R2: Once the logic supply has turned off, it stays off until the lockout delay has elapsed. A request that arrives while the supply is off but the lockout is still running does not start the supply early.
- R3: When the request is high and the block is idle, the logic supply enable rises one clock later. The signal enable rises after the signal delay, which must be below 10 ms. The signal enable is never high while the supply enable is low.
- R4: The backlight supply enable rises after the backlight delay (default 180 ms, so 181 pulses) has counted from the rise of the signal enable.
- R5: The backlight on control rises after the backlight-on delay (default 0, so one clock) from the rise of the backlight supply enable, and never while that supply is off.
- R6: The backlight supply enable is never high without the signal enable.
- R7: When the request drops in the fully-on state, the enables fall in this order: backlight on, backlight supply, signals, logic supply. With the default zero power-down delays, each falls one clock after the one before it.
- R8: If the request drops during power-up, the block turns off only the enables already on, in power-down order. With the supply alone on, the supply falls two clocks after the request drops. With supply and signals on, the signals fall two clocks after the request and the supply one clock after that. Enables that were still off never rise.
- R9: Ready is 1 only in the fully-on state. Busy is 1 in every transition state and during the lockout. Ready and busy are never both 1. Both are 0 when the block is idle and off.
- R10: A request that rises again during power-down or the lockout is held until the lockout ends. The next supply rise then comes exactly the lockout delay's pulse count after the supply fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_req | input | 1 | Level request: 1 = panel on, 0 = panel off |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| sup_en | output | 1 | Panel logic supply enable |
| sig_en | output | 1 | Video interface signal enable (0 holds outputs low) |
| bl_pwr_en | output | 1 | Backlight low-voltage supply enable |
| bl_on | output | 1 | Backlight on/off control |
| busy | output | 1 | Sequence in progress or restart lockout running |
| ready | output | 1 | Panel fully on |

## Verification
The bench measures each gap in tick pulses between one enable edge and the next. A design that counted one pulse too few would break the minimum-time guarantee, and the bench sees this as a count one short. It drops the request while only the supply is on, and again with supply and signals on. A design that jumped straight to the full power-down path would pulse the backlight enables, or would lose the two-clock fall timing. It raises the request again during power-down and during the lockout. A design that restarted early would show a shorter supply-off interval than the lockout count.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [3:0] {
    ST_OFF, ST_UP_SUP, ST_UP_SIG, ST_UP_BLP, ST_ON,
    ST_DN_BLP, ST_DN_SIG, ST_DN_SUP, ST_LOCK
  } pps_state_e;

  typedef struct packed {
    logic sup;
    logic sig;
    logic blp;
    logic blon;
    logic busy;
    logic ready;
  } pps_outs_t;

  // A delay of d ms needs d+1 tick edges to guarantee d full ms; 0 means none
  function automatic int ticks_needed(input int d);
    return (d == 0) ? 0 : d + 1;
  endfunction

  function automatic pps_outs_t outs_of(input pps_state_e s);
    pps_outs_t o;
    o = '0;
    case (s)
      ST_UP_SUP, ST_DN_SUP:  o.sup = 1'b1;
      ST_UP_SIG, ST_DN_SIG:  begin o.sup = 1'b1; o.sig = 1'b1; end
      ST_UP_BLP, ST_DN_BLP:  begin o.sup = 1'b1; o.sig = 1'b1; o.blp = 1'b1; end
      ST_ON:                 begin o.sup = 1'b1; o.sig = 1'b1; o.blp = 1'b1; o.blon = 1'b1; end
      default:               o = '0;
    endcase
    o.busy  = (s != ST_OFF) && (s != ST_ON);
    o.ready = (s == ST_ON);
    return o;
  endfunction

endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (clr)                      cnt <= '0;
    else if (tick && (cnt != '1))      cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= limit);

  // R2: count never wraps back below a reached limit
  cnt_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && $past(cnt) == '1 && !$past(clr)) |-> cnt == '1);
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
#(
  parameter int LOCK_DLY   = 150,
  parameter int SIG_DLY    = 0,
  parameter int BL_DLY     = 180,
  parameter int BLON_DLY   = 0,
  parameter int DN_BL_DLY  = 0,
  parameter int DN_SIG_DLY = 0,
  parameter int DN_SUP_DLY = 0,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          tick,
  input  logic          done,
  output logic          state_chg,
  output logic [CW-1:0] limit,
  output pps_outs_t     outs
);
  localparam int LOCK_NEED = ticks_needed(LOCK_DLY);

  pps_state_e state_q, state_d;
  logic [CW-1:0] off_ms;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:    if (req) state_d = ST_UP_SUP;
      ST_UP_SUP: if (!req) state_d = ST_DN_SUP; else if (done) state_d = ST_UP_SIG;
      ST_UP_SIG: if (!req) state_d = ST_DN_SIG; else if (done) state_d = ST_UP_BLP;
      ST_UP_BLP: if (!req) state_d = ST_DN_BLP; else if (done) state_d = ST_ON;
      ST_ON:     if (!req) state_d = ST_DN_BLP;
      ST_DN_BLP: if (done) state_d = ST_DN_SIG;
      ST_DN_SIG: if (done) state_d = ST_DN_SUP;
      ST_DN_SUP: if (done) state_d = ST_LOCK;
      ST_LOCK:   if (done) state_d = ST_OFF;
      default:   state_d = ST_LOCK;
    endcase
  end

  assign state_chg = (state_d != state_q);

  always_comb begin
    case (state_q)
      ST_UP_SUP: limit = CW'(ticks_needed(SIG_DLY));
      ST_UP_SIG: limit = CW'(ticks_needed(BL_DLY));
      ST_UP_BLP: limit = CW'(ticks_needed(BLON_DLY));
      ST_DN_BLP: limit = CW'(ticks_needed(DN_BL_DLY));
      ST_DN_SIG: limit = CW'(ticks_needed(DN_SIG_DLY));
      ST_DN_SUP: limit = CW'(ticks_needed(DN_SUP_DLY));
      ST_LOCK:   limit = CW'(LOCK_NEED);
      default:   limit = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOCK;
      outs    <= outs_of(ST_LOCK);
    end else begin
      state_q <= state_d;
      outs    <= outs_of(state_d);
    end
  end

  // Independent supply-off time meter, used only by the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          off_ms <= '0;
    else if (outs.sup)                   off_ms <= '0;
    else if (tick && (off_ms != '1))     off_ms <= off_ms + 1'b1;
  end

  // R2
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outs.sup) |-> $past(off_ms) >= CW'(LOCK_NEED));
  // R8
  abort_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req && !outs.blp |=> !$rose(outs.blp));
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int LOCK_DLY   = 150,
  parameter int SIG_DLY    = 0,
  parameter int BL_DLY     = 180,
  parameter int BLON_DLY   = 0,
  parameter int DN_BL_DLY  = 0,
  parameter int DN_SIG_DLY = 0,
  parameter int DN_SUP_DLY = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_req,
  input  logic ms_tick,
  output logic sup_en,
  output logic sig_en,
  output logic bl_pwr_en,
  output logic bl_on,
  output logic busy,
  output logic ready
);
  localparam int MAX_A   = (LOCK_DLY > BL_DLY) ? LOCK_DLY : BL_DLY;
  localparam int MAX_B   = (SIG_DLY > BLON_DLY) ? SIG_DLY : BLON_DLY;
  localparam int MAX_C   = (DN_BL_DLY > DN_SIG_DLY) ? DN_BL_DLY : DN_SIG_DLY;
  localparam int MAX_D   = (DN_SUP_DLY > MAX_C) ? DN_SUP_DLY : MAX_C;
  localparam int MAX_E   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_DLY = (MAX_E > MAX_D) ? MAX_E : MAX_D;
  localparam int CW      = $clog2(ticks_needed(MAX_DLY) + 2);

  logic          state_chg;
  logic          step_done;
  logic [CW-1:0] step_limit;
  pps_outs_t     outs;

  pps_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(state_chg), .tick(ms_tick),
    .limit(step_limit), .done(step_done)
  );

  pps_fsm #(
    .LOCK_DLY(LOCK_DLY), .SIG_DLY(SIG_DLY), .BL_DLY(BL_DLY), .BLON_DLY(BLON_DLY),
    .DN_BL_DLY(DN_BL_DLY), .DN_SIG_DLY(DN_SIG_DLY), .DN_SUP_DLY(DN_SUP_DLY), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(on_req), .tick(ms_tick), .done(step_done),
    .state_chg(state_chg), .limit(step_limit), .outs(outs)
  );

  assign sup_en    = outs.sup;
  assign sig_en    = outs.sig;
  assign bl_pwr_en = outs.blp;
  assign bl_on     = outs.blon;
  assign busy      = outs.busy;
  assign ready     = outs.ready;

  // R3
  sig_under_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_en |-> sup_en);
  // R6
  blp_under_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bl_pwr_en |-> sig_en);
  // R5
  blon_after_blp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_on) |-> $past(bl_pwr_en));
  // R7
  down_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sig_en) |-> !bl_pwr_en && !bl_on && sup_en);
  // R9
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({busy, ready}) <= 1 && (ready == bl_on));
endmodule

// File: tb/panel_pwr_seq_test.sv
module panel_pwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int SIG_D      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_req = 1'b0;
  logic ms_tick = 1'b0;
  logic sup_en, sig_en, bl_pwr_en, bl_on, busy, ready;
  int checks = 0;
  int errors = 0;
  int div = 0;

  panel_pwr_seq #(.SIG_DLY(SIG_D)) uut (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .ms_tick(ms_tick),
    .sup_en(sup_en), .sig_en(sig_en), .bl_pwr_en(bl_pwr_en), .bl_on(bl_on),
    .busy(busy), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    div     <= (div == TICK_DIV-1) ? 0 : div + 1;
    ms_tick <= (div == TICK_DIV-1);
  end

  function automatic int want_ticks(input int ms);
    if (ms > 0) return ms + 1;
    return 0;
  endfunction

  function automatic logic pick(input int sel);
    case (sel)
      0: return sup_en;
      1: return sig_en;
      2: return bl_pwr_en;
      3: return bl_on;
      4: return busy;
      default: return ready;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // From the current negedge, wait until output sel equals val
  task automatic wait_for(input int sel, input logic val, output int ticks, output int cycles);
    ticks = 0; cycles = 0;
    while (pick(sel) !== val) begin
      if (ms_tick) ticks++;
      @(negedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog waiting on output %0d", sel);
        return;
      end
    end
  endtask

  task automatic wait_idle();
    int t, c;
    wait_for(4, 1'b0, t, c);
  endtask

  task automatic t_reset();
    int t, c;
    #(CLK_PERIOD*3);
    @(negedge clk);
    check("R1 enables in reset", {sup_en, sig_en, bl_pwr_en, bl_on}, 0);
    check("R1 busy in reset", busy, 1);
    check("R1 ready in reset", ready, 0);
    rst_n = 1'b1;
    wait_for(4, 1'b0, t, c);
    check("R1 lockout pulses after reset", t, want_ticks(150));
    check("R9 idle ready", ready, 0);
  endtask

  task automatic t_powerup();
    int t, c;
    on_req = 1'b1;
    wait_for(0, 1'b1, t, c);
    check("R3 supply one clock after request", c, 1);
    check("R9 busy during power-up", busy, 1);
    wait_for(1, 1'b1, t, c);
    check("R3 signal delay pulses", t, want_ticks(SIG_D));
    wait_for(2, 1'b1, t, c);
    check("R4 backlight supply delay pulses", t, want_ticks(180));
    check("R6 signals on with backlight supply", sig_en, 1);
    wait_for(3, 1'b1, t, c);
    check("R5 backlight on one clock later", c, 1);
    check("R9 ready when on", ready, 1);
    check("R9 not busy when on", busy, 0);
  endtask

  task automatic t_powerdown();
    int t, c;
    on_req = 1'b0;
    wait_for(3, 1'b0, t, c);
    check("R7 backlight off first", c, 1);
    check("R7 backlight supply still on", bl_pwr_en, 1);
    check("R9 busy in power-down", busy, 1);
    wait_for(2, 1'b0, t, c);
    check("R7 backlight supply next", c, 1);
    check("R7 signals still on", sig_en, 1);
    on_req = 1'b1;  // R10: early request must be held
    wait_for(1, 1'b0, t, c);
    check("R7 signals next", c, 1);
    wait_for(0, 1'b0, t, c);
    check("R7 supply last", c, 1);
    wait_for(0, 1'b1, t, c);
    check("R10 R2 supply off interval pulses", t, want_ticks(150));
  endtask

  task automatic t_abort_sup();
    int t, c;
    logic saw_sig = 1'b0;
    // supply just rose; drop request at once
    on_req = 1'b0;
    c = 0;
    while (sup_en && c < 50) begin
      saw_sig |= sig_en;
      @(negedge clk); c++;
    end
    check("R8 supply-only abort falls in two clocks", c, 2);
    check("R8 signals never rose", saw_sig, 0);
    wait_idle();
  endtask

  task automatic t_abort_sig();
    int t, c;
    logic saw_blp = 1'b0;
    on_req = 1'b1;
    wait_for(1, 1'b1, t, c);
    repeat (20) @(negedge clk);
    on_req = 1'b0;
    c = 0;
    while (sig_en && c < 50) begin
      saw_blp |= bl_pwr_en | bl_on;
      @(negedge clk); c++;
    end
    check("R8 signals fall two clocks after request", c, 2);
    check("R8 supply still on after signals", sup_en, 1);
    wait_for(0, 1'b0, t, c);
    check("R8 supply falls next clock", c, 1);
    check("R8 backlight never rose", saw_blp, 0);
    // R2: request during lockout does not start supply early
    @(negedge clk);
    on_req = 1'b1;
    wait_for(0, 1'b1, t, c);
    check("R2 lockout held under request", busy === 1'b1 && t + 1 >= want_ticks(150) - 1, 1);
    on_req = 1'b0;
    wait_idle();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_powerup();
        t_powerdown();
        t_abort_sup();
        t_abort_sig();
      end
      begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule